// File: doc/BRIEF.md
# Floating-point control and status register pair

This block keeps the two software-visible registers that steer a small floating-point unit. The control register holds the rounding mode, which is driven straight to the arithmetic datapath, and a five-bit exception-enable field. The status register holds five exception flags. These flags are sticky: every completing operation reports its flags, and the block ORs them in. Software can read each register back and can overwrite it.

Each register has its own 32-bit write port, and each write is masked to that register's implemented bits. The upper twenty bits of both registers must be zero. If software writes a one into any of them, the block stores the masked value anyway and raises a single-cycle error pulse, which the surrounding logic can log. The flag field sits at a fixed position in the status word. The bit order inside the flag field is the same in the status register, in the enable field and on the flag-report input.

Top module: `fp_ctl_stat`

## Requirements
- R1: While reset is asserted, and right after it, both read ports return zero, the rounding mode is 0 (nearest even) and the error output is low.
- R2: A control write keeps only bits [6:0]. Control readback bits [31:7] are always zero, and the control register holds its value when it is not written.
- R3: The rounding-mode output equals control bits [1:0]: 0 is nearest even, 1 is toward zero, 2 is toward +infinity, 3 is toward -infinity. Control bits [6:2] are the exception enables, in flag order.
- R4: A status write keeps only bits [11:7]. Status readback returns the flag set shifted left by 7, so bits [6:0] and [31:12] read zero.
- R5: Flag order is: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. A report with the valid input high ORs its flags into the held set.
- R6: A held flag stays set until a status write clears it.
- R7: When a status write and a valid flag report occur in the same cycle, the new flags are the written flags ORed with the reported flags.
- R8: A write to either register with any of bits [31:12] set raises the error output for exactly the next cycle, and the masked value is still stored.
- R9: A write with no bits set in [31:12] raises no error, even if it has bits set that the register drops.
- R10: Flag inputs are ignored while the report-valid input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 32 | Control register write value |
| ctl_rdata_o | output | 32 | Control register readback |
| sts_we_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | 32 | Status register write value |
| sts_rdata_o | output | 32 | Status register readback |
| flag_vld_i | input | 1 | Flag report from a completing operation is valid |
| flag_i | input | 5 | Reported exception flags, in flag order |
| rnd_mode_o | output | 2 | Rounding mode to the datapath |
| mbz_err_o | output | 1 | One-cycle pulse after a write to must-be-zero bits |

## Verification
Each write, each flag report and each error pulse is registered once at the clock edge. So every result, including the readback values, the rounding mode and the error pulse, is due one cycle after the stimulus is applied. The bench applies each vector at a falling edge and compares all four outputs at the next falling edge, half a period after the capturing rising edge. It checks the reset state while reset is still held, before any clock edge has a chance to move it. It checks the single-cycle width of the error pulse on the idle cycle that follows.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;
  localparam int XLEN     = 32;
  localparam int NFLAG    = 5;
  localparam int RM_W     = 2;
  localparam int FLAG_POS = 7;
  localparam int MBZ_POS  = 12;
  localparam int CTL_KEEP = RM_W + NFLAG;

  // flag order, shared by status field, enable field and report input
  localparam int FLG_INEXACT = 0;
  localparam int FLG_UNDER   = 1;
  localparam int FLG_OVER    = 2;
  localparam int FLG_DIVZ    = 3;
  localparam int FLG_INVAL   = 4;

  typedef enum logic [RM_W-1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_POS_INF   = 2'd2,
    RM_NEG_INF   = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/fpcs_ctl_reg.sv
module fpcs_ctl_reg #(
  parameter int XLEN   = fpcs_pkg::XLEN,
  parameter int KEEP_W = fpcs_pkg::CTL_KEEP
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [KEEP_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i[KEEP_W-1:0];
  end

  assign rdata_o = {{(XLEN-KEEP_W){1'b0}}, q};

  p_ctl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
  p_ctl_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[KEEP_W-1:0] == $past(wdata_i[KEEP_W-1:0]));
endmodule

// File: rtl/fpcs_flag_reg.sv
module fpcs_flag_reg #(
  parameter int XLEN     = fpcs_pkg::XLEN,
  parameter int NFLAG    = fpcs_pkg::NFLAG,
  parameter int FLAG_POS = fpcs_pkg::FLAG_POS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic             vld_i,
  input  logic [NFLAG-1:0] flag_i,
  output logic [XLEN-1:0]  rdata_o
);
  logic [NFLAG-1:0] q;
  logic [NFLAG-1:0] rpt;

  assign rpt = vld_i ? flag_i : '0;

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    // write lands first, report is ORed on top
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q[i] <= 1'b0;
      else if (we_i)   q[i] <= wdata_i[FLAG_POS+i] | rpt[i];
      else if (rpt[i]) q[i] <= 1'b1;
    end
  end

  assign rdata_o = {{(XLEN-NFLAG){1'b0}}, q} << FLAG_POS;

  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !we_i) |=> ((q & $past(flag_i)) == $past(flag_i)));
  p_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ((q & $past(q)) == $past(q)));
  p_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !we_i) |=> $stable(q));
  p_merge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && we_i) |=> q == ($past(wdata_i[FLAG_POS +: NFLAG]) | $past(flag_i)));
endmodule

// File: rtl/fpcs_mbz_chk.sv
module fpcs_mbz_chk #(
  parameter int XLEN    = fpcs_pkg::XLEN,
  parameter int NPORT   = 2,
  parameter int MBZ_POS = fpcs_pkg::MBZ_POS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPORT-1:0]           we_i,
  input  logic [NPORT-1:0][XLEN-1:0] wdata_i,
  output logic                       err_o
);
  logic [NPORT-1:0] hit;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign hit[p] = we_i[p] & (|wdata_i[p][XLEN-1:MBZ_POS]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= |hit;
  end

  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit) |=> err_o);
  p_no_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|hit) |=> !err_o);
endmodule

// File: rtl/fp_ctl_stat.sv
module fp_ctl_stat
  import fpcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [XLEN-1:0]  ctl_wdata_i,
  output logic [XLEN-1:0]  ctl_rdata_o,
  input  logic             sts_we_i,
  input  logic [XLEN-1:0]  sts_wdata_i,
  output logic [XLEN-1:0]  sts_rdata_o,
  input  logic             flag_vld_i,
  input  logic [NFLAG-1:0] flag_i,
  output logic [RM_W-1:0]  rnd_mode_o,
  output logic             mbz_err_o
);
  rnd_mode_e rm;

  fpcs_ctl_reg #(.XLEN(XLEN), .KEEP_W(CTL_KEEP)) u_ctl (
    .clk_i, .rst_ni, .we_i(ctl_we_i), .wdata_i(ctl_wdata_i), .rdata_o(ctl_rdata_o)
  );

  fpcs_flag_reg #(.XLEN(XLEN), .NFLAG(NFLAG), .FLAG_POS(FLAG_POS)) u_flags (
    .clk_i, .rst_ni, .we_i(sts_we_i), .wdata_i(sts_wdata_i),
    .vld_i(flag_vld_i), .flag_i, .rdata_o(sts_rdata_o)
  );

  fpcs_mbz_chk #(.XLEN(XLEN), .NPORT(2), .MBZ_POS(MBZ_POS)) u_mbz (
    .clk_i, .rst_ni,
    .we_i({sts_we_i, ctl_we_i}),
    .wdata_i({sts_wdata_i, ctl_wdata_i}),
    .err_o(mbz_err_o)
  );

  assign rm         = rnd_mode_e'(ctl_rdata_o[RM_W-1:0]);
  assign rnd_mode_o = rm;

  p_rm_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> rnd_mode_o == $past(ctl_wdata_i[RM_W-1:0]));
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (ctl_rdata_o == '0 && sts_rdata_o == '0 && !mbz_err_o));
endmodule

// File: tb/fp_ctl_stat_bench.sv
module fp_ctl_stat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, sts_we = 1'b0, fvld = 1'b0;
  logic [31:0] ctl_wd = '0, sts_wd = '0;
  logic [4:0]  fl = '0;
  logic [31:0] ctl_rd, sts_rd;
  logic [1:0]  rm;
  logic        err;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  fp_ctl_stat u_fp_ctl_stat (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd), .ctl_rdata_o(ctl_rd),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wd), .sts_rdata_o(sts_rd),
    .flag_vld_i(fvld), .flag_i(fl), .rnd_mode_o(rm), .mbz_err_o(err)
  );

  typedef struct packed {
    logic cwe; logic [31:0] cwd; logic swe; logic [31:0] swd;
    logic fv; logic [4:0] f;
    logic [31:0] ectl; logic [31:0] ests; logic [1:0] erm; logic eerr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h0000_0045, 1'b0, 32'h0,         1'b0, 5'b00000, 32'h45, 32'h000, 2'd1, 1'b0},
    '{1'b1, 32'hFFFF_0F7E, 1'b0, 32'h0,         1'b0, 5'b00000, 32'h7E, 32'h000, 2'd2, 1'b1},
    '{1'b1, 32'h0000_0F83, 1'b0, 32'h0,         1'b0, 5'b00000, 32'h03, 32'h000, 2'd3, 1'b0},
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 5'b00001, 32'h03, 32'h080, 2'd3, 1'b0},
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 5'b10000, 32'h03, 32'h880, 2'd3, 1'b0},
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 5'b11111, 32'h03, 32'h880, 2'd3, 1'b0},
    '{1'b0, 32'h0,         1'b1, 32'h0000_0000, 1'b0, 5'b00000, 32'h03, 32'h000, 2'd3, 1'b0},
    '{1'b0, 32'h0,         1'b1, 32'h1234_5FFF, 1'b0, 5'b00000, 32'h03, 32'hF80, 2'd3, 1'b1},
    '{1'b0, 32'h0,         1'b1, 32'h0000_0100, 1'b1, 5'b00100, 32'h03, 32'h300, 2'd3, 1'b0},
    '{1'b0, 32'h0,         1'b1, 32'h0000_007F, 1'b1, 5'b01000, 32'h03, 32'h400, 2'd3, 1'b0},
    '{1'b1, 32'h8000_0000, 1'b1, 32'h0000_0080, 1'b0, 5'b00000, 32'h00, 32'h080, 2'd0, 1'b1},
    '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 5'b00000, 32'h00, 32'h080, 2'd0, 1'b0}
  };

  function automatic string req_of(int i);
    case (i)
      0: return "R2/R3 ctl store";
      1: return "R8 ctl mbz";
      2: return "R9 dropped bits";
      3: return "R5 inexact";
      4: return "R5 invalid";
      5: return "R10 ignore";
      6: return "R6 clear";
      7: return "R4 sts mask";
      8: return "R7 merge";
      9: return "R7 low bits";
      10: return "R8 both ports";
      default: return "R8 pulse width";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    #5;
    chk("R1", "ctl", ctl_rd, 32'h0);
    chk("R1", "sts", sts_rd, 32'h0);
    chk("R1", "rm", {30'b0, rm}, 32'h0);
    chk("R1", "err", {31'b0, err}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ctl after", ctl_rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      ctl_we = VEC[i].cwe; ctl_wd = VEC[i].cwd;
      sts_we = VEC[i].swe; sts_wd = VEC[i].swd;
      fvld = VEC[i].fv; fl = VEC[i].f;
      @(negedge clk);
      chk(req_of(i), "ctl", ctl_rd, VEC[i].ectl);
      chk(req_of(i), "sts", sts_rd, VEC[i].ests);
      chk(req_of(i), "rm", {30'b0, rm}, {30'b0, VEC[i].erm});
      chk(req_of(i), "err", {31'b0, err}, {31'b0, VEC[i].eerr});
    end

    // R3: every rounding mode code
    for (int m = 0; m < 4; m++) begin
      ctl_we = 1'b1; ctl_wd = 32'h7C | m;
      @(negedge clk);
      chk("R3", "rm code", {30'b0, rm}, m);
    end
    ctl_we = 1'b0;
    @(negedge clk);
    chk("R2", "ctl hold", ctl_rd, 32'h7F);

    // R1: reset in mid-run clears both registers
    rst_n = 1'b0;
    #3;
    chk("R1", "ctl mid", ctl_rd, 32'h0);
    chk("R1", "sts mid", sts_rd, 32'h0);
    chk("R1", "rm mid", {30'b0, rm}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule